// File: doc/BRIEF.md
# Receive Transport Checksum Policy Gate

This block decides, for each received frame carrying UDP, UDP-Lite or ICMP, whether the frame is kept or thrown away on the strength of its transport checksum. A header parser upstream announces each frame with a one-cycle header pulse. The pulse carries a protocol code, a fragment flag, a flag saying the UDP checksum field reads zero, and the folded 16-bit sum of the pseudo-header. The parser then streams the transport segment as 16-bit words. The block forms their ones-complement sum with end-around carry.

One cycle after the final word, the block emits a verdict pulse. The pulse carries a keep/discard flag and a two-bit reason. Four policy bits, loaded through a write strobe, steer the verdict. They decide whether fragments bypass the check, whether a zero UDP checksum is tolerated, whether UDP-Lite is verified at all, and whether ICMP is checked. The ICMP check applies only to non-fragmented frames.

Top module: `l4_rx_csum_policy`

## Requirements
- R1: After reset, vrd_valid, vrd_pass and vrd_reason are 0. The policy is UDP-Lite checking on and every other policy bit off.
- R2: A cycle with pol_wr high loads pol_wdata into the policy, with bit 0 = fragment bypass, bit 1 = zero-checksum tolerance, bit 2 = UDP-Lite checking, bit 3 = ICMP checking. With pol_wr low the policy holds.
- R3: A checked frame is good when the ones-complement sum, with end-around carry, of the pseudo-header sum and every segment word equals 0xFFFF. Good gives pass=1 with reason 0 (ok). Otherwise the result is pass=0 with reason 1 (bad checksum). Protocol codes: 0 other, 1 UDP, 2 UDP-Lite, 3 ICMP.
- R4: When dat_lo_en is low on the last word, the low byte of that word is replaced by zero before summing. When it is high, the whole word is summed.
- R5: A UDP or UDP-Lite fragment with fragment bypass set passes with reason 3 (skipped) whatever its sum. With bypass clear, a fragment is checked as any other frame.
- R6: A UDP frame (not UDP-Lite) flagged with a zero checksum field reports reason 2 (zero checksum). It passes if zero-checksum tolerance is set and is dropped if it is clear. Fragment bypass takes priority.
- R7: With UDP-Lite checking set, UDP-Lite frames are checked per R3. With it clear, they pass with reason 3.
- R8: With ICMP checking set, non-fragment ICMP frames are checked per R3 with no pseudo-header: the header sum is ignored. ICMP fragments, and all ICMP frames when checking is clear, pass with reason 3.
- R9: Frames of any other protocol pass with reason 0 whatever their sum.
- R10: vrd_valid is a single-cycle pulse in the cycle after the word with dat_last. It stays low before that, including across idle gaps in the word stream.
- R11: A drop always carries reason 1 or 2. Reason 3 only ever accompanies a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pol_wr | input | 1 | Policy load strobe |
| pol_wdata | input | 4 | Policy value (encoding in R2) |
| hdr_valid | input | 1 | Start-of-frame header pulse |
| hdr_proto | input | 2 | Protocol code (R3) |
| hdr_frag | input | 1 | Frame is a fragment |
| hdr_csum_zero | input | 1 | UDP checksum field is zero |
| hdr_ph_sum | input | 16 | Folded pseudo-header sum |
| dat_valid | input | 1 | Segment word valid |
| dat_word | input | 16 | Segment word, first byte in the high half |
| dat_last | input | 1 | Final word of the segment |
| dat_lo_en | input | 1 | Low byte of the final word is real data |
| vrd_valid | output | 1 | Verdict pulse |
| vrd_pass | output | 1 | 1 = keep the frame, 0 = discard it |
| vrd_reason | output | 2 | 0 ok, 1 bad checksum, 2 zero checksum, 3 skipped |

## Verification
The assertions assume that each frame begins with exactly one header pulse, given while no frame is open. They assume every segment word arrives after that pulse and no later than the word marked last, and that a new header never shares a cycle with a word. The stimulus respects this by driving each frame as a policy write, then a header cycle, then the words, then an idle cycle before the next frame. Idle gaps are placed only between words of the same frame.

// File: rtl/l4_csum_pkg.sv
package l4_csum_pkg;

    typedef enum logic [1:0] {
        PR_OTHER = 2'd0,
        PR_UDP   = 2'd1,
        PR_LITE  = 2'd2,
        PR_ICMP  = 2'd3
    } proto_e;

    typedef enum logic [1:0] {
        RS_OK   = 2'd0,
        RS_BAD  = 2'd1,
        RS_ZERO = 2'd2,
        RS_SKIP = 2'd3
    } rsn_e;

    // Field order matches the write-data bit positions (bit 3 down to bit 0).
    typedef struct packed {
        logic icmp_chk;
        logic lite_chk;
        logic zero_pass;
        logic frag_pass;
    } policy_t;

    localparam int POL_W = $bits(policy_t);

    localparam policy_t POLICY_RST = '{
        icmp_chk:  1'b0,
        lite_chk:  1'b1,
        zero_pass: 1'b0,
        frag_pass: 1'b0
    };

    typedef struct packed {
        proto_e proto;
        logic   frag;
        logic   zero;
    } ctx_t;

endpackage

// File: rtl/l4_policy_regs.sv
module l4_policy_regs
    import l4_csum_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [POL_W-1:0] wdata,
    output policy_t          pol
);

    typedef struct packed {
        policy_t pol;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.pol = policy_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pol <= POLICY_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pol = st_q.pol;

    AST_POLICY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (pol == policy_t'($past(wdata)))); // R2
    AST_POLICY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(pol)); // R2

endmodule

// File: rtl/l4_frame_ctx.sv
module l4_frame_ctx
    import l4_csum_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hdr_valid,
    input  logic [1:0] hdr_proto,
    input  logic       hdr_frag,
    input  logic       hdr_zero,
    input  logic       dat_valid,
    input  logic       dat_last,
    output ctx_t       ctx,
    output logic       in_frame
);

    typedef struct packed {
        ctx_t ctx;
        logic open;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hdr_valid) begin
            st_d.ctx.proto = proto_e'(hdr_proto);
            st_d.ctx.frag  = hdr_frag;
            st_d.ctx.zero  = hdr_zero;
            st_d.open      = 1'b1;
        end else if (dat_valid && dat_last) begin
            st_d.open      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctx.proto <= PR_OTHER;
            st_q.ctx.frag  <= 1'b0;
            st_q.ctx.zero  <= 1'b0;
            st_q.open      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctx      = st_q.ctx;
    assign in_frame = st_q.open;

    AST_WORD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |-> (in_frame && !hdr_valid)); // R10
    AST_HDR_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !in_frame); // R10

endmodule

// File: rtl/l4_ones_acc.sv
module l4_ones_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed_load,
    input  logic [W-1:0] seed,
    input  logic         dat_valid,
    input  logic [W-1:0] dat_word,
    input  logic         dat_last,
    input  logic         dat_lo_en,
    output logic [W-1:0] sum_now
);

    localparam int HB = W / 2;

    typedef struct packed {
        logic [W-1:0] acc;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] word_m;
    logic [W:0]   raw;
    logic [W-1:0] folded;

    always_comb begin
        word_m = dat_word;
        if (dat_last && !dat_lo_en) begin
            word_m = {dat_word[W-1:HB], {HB{1'b0}}};
        end
        raw    = {1'b0, st_q.acc} + {1'b0, word_m};
        folded = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};

        st_d = st_q;
        if (seed_load) begin
            st_d.acc = seed;
        end else if (dat_valid) begin
            st_d.acc = folded;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_now = folded;

    AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (st_q.acc == $past(seed))); // R3
    AST_NONZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && !seed_load && (word_m != '0)) |=> (st_q.acc != '0)); // R3
    AST_PAD_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_last && !dat_lo_en) |-> (word_m[HB-1:0] == '0)); // R4

endmodule

// File: rtl/l4_verdict.sv
module l4_verdict
    import l4_csum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  policy_t      pol,
    input  ctx_t         ctx,
    input  logic         fire,
    input  logic [W-1:0] sum_final,
    output logic         vrd_valid,
    output logic         vrd_pass,
    output logic [1:0]   vrd_reason
);

    typedef struct packed {
        logic valid;
        logic pass;
        rsn_e rsn;
    } st_t;

    st_t  st_d, st_q;
    logic good;
    logic bypass;

    always_comb begin
        good   = (sum_final == {W{1'b1}});
        bypass = ctx.frag && pol.frag_pass;
        st_d       = st_q;
        st_d.valid = fire;
        if (fire) begin
            unique case (ctx.proto)
                PR_UDP: begin
                    if (bypass) begin
                        st_d.pass = 1'b1;
                        st_d.rsn  = RS_SKIP;
                    end else if (ctx.zero) begin
                        st_d.pass = pol.zero_pass;
                        st_d.rsn  = RS_ZERO;
                    end else begin
                        st_d.pass = good;
                        st_d.rsn  = good ? RS_OK : RS_BAD;
                    end
                end
                PR_LITE: begin
                    if (bypass || !pol.lite_chk) begin
                        st_d.pass = 1'b1;
                        st_d.rsn  = RS_SKIP;
                    end else begin
                        st_d.pass = good;
                        st_d.rsn  = good ? RS_OK : RS_BAD;
                    end
                end
                PR_ICMP: begin
                    if (pol.icmp_chk && !ctx.frag) begin
                        st_d.pass = good;
                        st_d.rsn  = good ? RS_OK : RS_BAD;
                    end else begin
                        st_d.pass = 1'b1;
                        st_d.rsn  = RS_SKIP;
                    end
                end
                default: begin
                    st_d.pass = 1'b1;
                    st_d.rsn  = RS_OK;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.pass  <= 1'b0;
            st_q.rsn   <= RS_OK;
        end else begin
            st_q <= st_d;
        end
    end

    assign vrd_valid  = st_q.valid;
    assign vrd_pass   = st_q.pass;
    assign vrd_reason = st_q.rsn;

    AST_ONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> vrd_valid); // R10
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_valid |=> !vrd_valid); // R10
    AST_DROP_REASON: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd_valid && !vrd_pass) |-> ((vrd_reason == RS_BAD) || (vrd_reason == RS_ZERO))); // R11
    AST_SKIP_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd_valid && (vrd_reason == RS_SKIP)) |-> vrd_pass); // R11
    AST_OTHER_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (ctx.proto == PR_OTHER)) |=> (vrd_pass && (vrd_reason == RS_OK))); // R9
    AST_ICMP_FRAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (ctx.proto == PR_ICMP) && ctx.frag) |=> vrd_pass); // R8
    AST_FRAG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (ctx.proto != PR_OTHER) && (ctx.proto != PR_ICMP) && ctx.frag && pol.frag_pass)
        |=> (vrd_pass && (vrd_reason == RS_SKIP))); // R5
    AST_UDP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (ctx.proto == PR_UDP) && ctx.zero && !(ctx.frag && pol.frag_pass))
        |=> (vrd_reason == RS_ZERO)); // R6

endmodule

// File: rtl/l4_rx_csum_policy.sv
module l4_rx_csum_policy
    import l4_csum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pol_wr,
    input  logic [3:0]   pol_wdata,
    input  logic         hdr_valid,
    input  logic [1:0]   hdr_proto,
    input  logic         hdr_frag,
    input  logic         hdr_csum_zero,
    input  logic [W-1:0] hdr_ph_sum,
    input  logic         dat_valid,
    input  logic [W-1:0] dat_word,
    input  logic         dat_last,
    input  logic         dat_lo_en,
    output logic         vrd_valid,
    output logic         vrd_pass,
    output logic [1:0]   vrd_reason
);

    policy_t      pol;
    ctx_t         ctx;
    logic         in_frame;
    logic [W-1:0] seed;
    logic [W-1:0] sum_now;
    logic         fire;

    // ICMP carries no pseudo-header: start its sum from zero.
    assign seed = (hdr_proto == PR_ICMP) ? '0 : hdr_ph_sum;
    assign fire = dat_valid && dat_last;

    l4_policy_regs u_pol (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (pol_wr),
        .wdata (pol_wdata),
        .pol   (pol)
    );

    l4_frame_ctx u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .hdr_proto (hdr_proto),
        .hdr_frag  (hdr_frag),
        .hdr_zero  (hdr_csum_zero),
        .dat_valid (dat_valid),
        .dat_last  (dat_last),
        .ctx       (ctx),
        .in_frame  (in_frame)
    );

    l4_ones_acc #(.W(W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (hdr_valid),
        .seed      (seed),
        .dat_valid (dat_valid),
        .dat_word  (dat_word),
        .dat_last  (dat_last),
        .dat_lo_en (dat_lo_en),
        .sum_now   (sum_now)
    );

    l4_verdict #(.W(W)) u_vrd (
        .clk        (clk),
        .rst_n      (rst_n),
        .pol        (pol),
        .ctx        (ctx),
        .fire       (fire),
        .sum_final  (sum_now),
        .vrd_valid  (vrd_valid),
        .vrd_pass   (vrd_pass),
        .vrd_reason (vrd_reason)
    );

    AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && !$past(in_frame)) |-> !vrd_valid); // R10

endmodule

// File: tb/sim_l4_rx_csum_policy.sv
module sim_l4_rx_csum_policy;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pol_wr = 1'b0;
    logic [3:0]  pol_wdata = '0;
    logic        hdr_valid = 1'b0;
    logic [1:0]  hdr_proto = '0;
    logic        hdr_frag = 1'b0;
    logic        hdr_csum_zero = 1'b0;
    logic [15:0] hdr_ph_sum = '0;
    logic        dat_valid = 1'b0;
    logic [15:0] dat_word = '0;
    logic        dat_last = 1'b0;
    logic        dat_lo_en = 1'b1;
    logic        vrd_valid;
    logic        vrd_pass;
    logic [1:0]  vrd_reason;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    l4_rx_csum_policy u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pol_wr        (pol_wr),
        .pol_wdata     (pol_wdata),
        .hdr_valid     (hdr_valid),
        .hdr_proto     (hdr_proto),
        .hdr_frag      (hdr_frag),
        .hdr_csum_zero (hdr_csum_zero),
        .hdr_ph_sum    (hdr_ph_sum),
        .dat_valid     (dat_valid),
        .dat_word      (dat_word),
        .dat_last      (dat_last),
        .dat_lo_en     (dat_lo_en),
        .vrd_valid     (vrd_valid),
        .vrd_pass      (vrd_pass),
        .vrd_reason    (vrd_reason)
    );

    typedef struct packed {
        logic [3:0]  pol;    // bit3 icmp, bit2 lite, bit1 zero-ok, bit0 frag bypass
        logic [1:0]  proto;  // 0 other, 1 udp, 2 lite, 3 icmp
        logic        frag;
        logic        zero;
        logic [15:0] seed;
        logic [1:0]  n;
        logic [15:0] w0;
        logic [15:0] w1;
        logic [15:0] w2;
        logic        lo;
        logic        xp;
        logic [1:0]  xr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{4'b0100, 2'd1, 1'b0, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFE, 16'h0, 1'b1, 1'b1, 2'd0, 4'd3},  // R3 good, carry
        '{4'b0100, 2'd1, 1'b0, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b0, 2'd1, 4'd3},  // R3 bad
        '{4'b0100, 2'd1, 1'b0, 1'b0, 16'hFFFE, 2'd1, 16'h0001, 16'h0,    16'h0, 1'b1, 1'b1, 2'd0, 4'd3},  // R3 one word
        '{4'b0100, 2'd1, 1'b0, 1'b0, 16'h0001, 2'd3, 16'h4000, 16'h4000, 16'h7FFE, 1'b1, 1'b1, 2'd0, 4'd3}, // R3 three words
        '{4'b0100, 2'd1, 1'b0, 1'b0, 16'h00FF, 2'd2, 16'h1000, 16'hEF55, 16'h0, 1'b0, 1'b1, 2'd0, 4'd4},  // R4 padded
        '{4'b0100, 2'd1, 1'b0, 1'b0, 16'h00FF, 2'd2, 16'h1000, 16'hEF55, 16'h0, 1'b1, 1'b0, 2'd1, 4'd4},  // R4 full word
        '{4'b0101, 2'd1, 1'b1, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b1, 2'd3, 4'd5},  // R5 bypass
        '{4'b0100, 2'd1, 1'b1, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b0, 2'd1, 4'd5},  // R5 checked bad
        '{4'b0100, 2'd1, 1'b1, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFE, 16'h0, 1'b1, 1'b1, 2'd0, 4'd5},  // R5 checked good
        '{4'b0101, 2'd2, 1'b1, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b1, 2'd3, 4'd5},  // R5 lite bypass
        '{4'b0100, 2'd1, 1'b0, 1'b1, 16'hF000, 2'd2, 16'h2000, 16'hEFFE, 16'h0, 1'b1, 1'b0, 2'd2, 4'd6},  // R6 zero dropped
        '{4'b0110, 2'd1, 1'b0, 1'b1, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b1, 2'd2, 4'd6},  // R6 zero kept
        '{4'b0101, 2'd1, 1'b1, 1'b1, 16'hF000, 2'd2, 16'h2000, 16'hEFFE, 16'h0, 1'b1, 1'b1, 2'd3, 4'd6},  // R6 bypass first
        '{4'b0100, 2'd2, 1'b0, 1'b1, 16'hF000, 2'd2, 16'h2000, 16'hEFFE, 16'h0, 1'b1, 1'b1, 2'd0, 4'd6},  // R6 lite ignores flag
        '{4'b0100, 2'd2, 1'b0, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b0, 2'd1, 4'd7},  // R7 lite bad
        '{4'b0100, 2'd2, 1'b0, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFE, 16'h0, 1'b1, 1'b1, 2'd0, 4'd7},  // R7 lite good
        '{4'b0000, 2'd2, 1'b0, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b1, 2'd3, 4'd7},  // R7 lite unchecked
        '{4'b1100, 2'd3, 1'b0, 1'b0, 16'h1111, 2'd2, 16'h8000, 16'h7FFF, 16'h0, 1'b1, 1'b1, 2'd0, 4'd8},  // R8 seed ignored
        '{4'b1100, 2'd3, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h8000, 16'h7FFE, 16'h0, 1'b1, 1'b0, 2'd1, 4'd8},  // R8 bad
        '{4'b1100, 2'd3, 1'b1, 1'b0, 16'h0000, 2'd2, 16'h8000, 16'h7FFE, 16'h0, 1'b1, 1'b1, 2'd3, 4'd8},  // R8 fragment
        '{4'b0100, 2'd3, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h8000, 16'h7FFE, 16'h0, 1'b1, 1'b1, 2'd3, 4'd8},  // R8 unchecked
        '{4'b1111, 2'd0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h8000, 16'h7FFE, 16'h0, 1'b1, 1'b1, 2'd0, 4'd9}   // R9 other
    };

    task automatic chk(input bit ok, input int req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] pick(input vec_t v, input int i);
        return (i == 0) ? v.w0 : ((i == 1) ? v.w1 : v.w2);
    endfunction

    // Drive one frame; checks verdict timing (R10) and value.
    task automatic run_frame(input vec_t v, input bit do_wr, input bit gaps);
        @(negedge clk);
        pol_wr    = do_wr;
        pol_wdata = v.pol;
        @(negedge clk);
        pol_wr        = 1'b0;
        hdr_valid     = 1'b1;
        hdr_proto     = v.proto;
        hdr_frag      = v.frag;
        hdr_csum_zero = v.zero;
        hdr_ph_sum    = v.seed;
        @(negedge clk);
        hdr_valid = 1'b0;
        for (int i = 0; i < int'(v.n); i++) begin
            dat_valid = 1'b1;
            dat_word  = pick(v, i);
            dat_last  = (i == int'(v.n) - 1);
            dat_lo_en = (i == int'(v.n) - 1) ? v.lo : 1'b1;
            @(negedge clk);
            if (i < int'(v.n) - 1) begin
                chk(vrd_valid == 1'b0, 10, vrd_valid, 0); // R10 no early verdict
                if (gaps) begin
                    dat_valid = 1'b0;
                    @(negedge clk);
                    chk(vrd_valid == 1'b0, 10, vrd_valid, 0); // R10 gap
                end
            end
        end
        dat_valid = 1'b0;
        dat_last  = 1'b0;
        dat_lo_en = 1'b1;
        chk(vrd_valid == 1'b1, 10, vrd_valid, 1);
        chk(vrd_pass == v.xp, int'(v.req), vrd_pass, v.xp);
        chk(vrd_reason == v.xr, int'(v.req), vrd_reason, v.xr);
        if (vrd_pass == 1'b0) chk(vrd_reason inside {2'd1, 2'd2}, 11, vrd_reason, 1); // R11
        @(negedge clk);
        chk(vrd_valid == 1'b0, 10, vrd_valid, 0); // R10 single pulse
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        // R1: outputs idle under and after reset
        chk(vrd_valid == 1'b0, 1, vrd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vrd_valid == 1'b0, 1, vrd_valid, 0);
        chk(vrd_pass == 1'b0, 1, vrd_pass, 0);
        chk(vrd_reason == 2'd0, 1, vrd_reason, 0);

        // R1: default policy seen through behaviour, no write
        d = '{4'b0, 2'd2, 1'b0, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b0, 2'd1, 4'd1};
        run_frame(d, 1'b0, 1'b0);  // R1 lite checked by default
        d = '{4'b0, 2'd1, 1'b1, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b0, 2'd1, 4'd1};
        run_frame(d, 1'b0, 1'b0);  // R1 no fragment bypass
        d = '{4'b0, 2'd1, 1'b0, 1'b1, 16'hF000, 2'd2, 16'h2000, 16'hEFFE, 16'h0, 1'b1, 1'b0, 2'd2, 4'd1};
        run_frame(d, 1'b0, 1'b0);  // R1 zero checksum not tolerated
        d = '{4'b0, 2'd3, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h8000, 16'h7FFE, 16'h0, 1'b1, 1'b1, 2'd3, 4'd1};
        run_frame(d, 1'b0, 1'b0);  // R1 icmp unchecked

        // R2..R9 through the table, each row loads its policy
        for (int k = 0; k < NV; k++) begin
            run_frame(TBL[k], 1'b1, 1'b0);
        end

        // R2: policy write with strobe low must not take effect
        d = '{4'b0101, 2'd1, 1'b1, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b1, 2'd3, 4'd2};
        run_frame(d, 1'b1, 1'b0);
        d = '{4'b0100, 2'd1, 1'b1, 1'b0, 16'hF000, 2'd2, 16'h2000, 16'hEFFD, 16'h0, 1'b1, 1'b1, 2'd3, 4'd2};
        run_frame(d, 1'b0, 1'b0);  // bypass still set: pass skipped

        // R10: gaps in the word stream, three words
        d = '{4'b0100, 2'd1, 1'b0, 1'b0, 16'h0001, 2'd3, 16'h4000, 16'h4000, 16'h7FFE, 1'b1, 1'b1, 2'd0, 4'd10};
        run_frame(d, 1'b1, 1'b1);
        d = '{4'b0100, 2'd1, 1'b0, 1'b0, 16'h0001, 2'd3, 16'h4000, 16'h4000, 16'h7FFF, 1'b1, 1'b0, 2'd1, 4'd10};
        run_frame(d, 1'b1, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule